// File: doc/BRIEF.md
# Nine-Bit Symbol Error Corrector

This block repairs a stored sector after a Reed-Solomon decoder has located its errors. The sector is viewed as a packed stream of 512 nine-bit symbols, which occupies 576 bytes in a byte-wide single-port RAM outside the block. A symbol usually straddles two bytes. For each error record the block reads the two bytes that hold the symbol, XORs the nine-bit error mask in at the right bit position and writes both bytes back.

The decoder side supplies a 32-bit status word and up to `MAX_REC` 32-bit error records. Both are captured on `start`. The block then walks the records in order, touching the RAM only through its own port, and raises `done` for one cycle. Alongside `done` it gives a fail flag and the number of corrections it applied. These two results stay valid until the next `start`. Finding the syndromes and error locations is not part of this block.

Top module: `sym9_fixer`

## Requirements
- R1: Each error record holds a one-based symbol number in bits 24:16 and a nine-bit XOR mask in bits 8:0. Every other record bit is ignored.
- R2: In the status word, bit 0 means errors are present, bit 1 means they cannot be corrected, and bits 31:29 give the error count.
- R3: When bit 1 of the status word is set together with bit 0, the block writes nothing to the RAM, reports `fail`=1 with `fix_count`=0, and pulses `done`.
- R4: When bit 0 of the status word is clear, the block writes nothing and reports `done` with `fail`=0 and `fix_count`=0, whatever the count field holds.
- R5: A record with symbol number 0 has no effect on the RAM. It still counts as one of the processed records.
- R6: For zero-based symbol i (symbol number minus 1), the low byte sits at RAM address i + (i >> 3) and the high byte at the next address. Together they form a little-endian 16-bit word, and the symbol starts at bit i & 7 of that word.
- R7: The nine bits of the symbol are XORed with the mask. Every other bit of the two bytes keeps its value.
- R8: Records are applied in order from 0 to n-1, where n is the count field limited to `MAX_REC`. Two records that hit the same symbol therefore both take effect. On success `fix_count` equals n.
- R9: A record that is not skipped causes exactly this access order: read the low byte, read the high byte, write the low byte, write the high byte. The RAM port performs one access per cycle.
- R10: `done` is high for one cycle only. `busy` is high from the cycle after `start` until `done`, and `fail` and `fix_count` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a correction pass; sampled while idle |
| status_word | input | 32 | Decoder status (flags and error count) |
| rec_words | input | 32*MAX_REC | Error records, record k in bits 32k+31:32k |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after a read |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Errors were uncorrectable |
| fix_count | output | 3 | Number of corrections applied |

## Verification
The bench targets the symbols that cross byte boundaries. It uses bit offset 7 at the start of the sector and symbol 511 near its end. A design that got the address or shift formula wrong would corrupt a neighbouring byte or miss the high byte. Two records that hit the same symbol check the ordering: a design that read stale data or dropped a record would leave only one mask applied. A count of 7 must be limited to four records, and a design that did not limit it would run on past the record list. Separate passes cover the uncorrectable case, a clear error flag and a record with symbol number 0. A design that wrote anyway in any of these cases would show a changed RAM image or extra write cycles.

// File: rtl/sym9_pkg.sv
package sym9_pkg;

    localparam int SYM_W     = 9;
    localparam int NUM_SYM   = 512;
    localparam int MEM_BYTES = NUM_SYM + NUM_SYM / 8;
    localparam int ADDR_W    = $clog2(MEM_BYTES);
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 3;

    // record field positions
    localparam int IDX_LSB  = 16;
    localparam int MASK_LSB = 0;

    // status field positions
    localparam int ST_ERR_BIT   = 0;
    localparam int ST_UNCOR_BIT = 1;
    localparam int ST_CNT_LSB   = 29;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        off;
        logic [SYM_W-1:0]  mask;
    } fix_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EVAL,
        ST_RD_LO,
        ST_RD_HI,
        ST_MODIFY,
        ST_WR_LO,
        ST_WR_HI,
        ST_NEXT,
        ST_FIN
    } seq_state_t;

    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] byte_addr(input logic [SYM_W-1:0] i);
        return ADDR_W'(i) + ADDR_W'(i >> 3);
    endfunction

    function automatic logic [15:0] place_mask(input logic [SYM_W-1:0] m,
                                               input logic [2:0] off);
        return 16'(m) << off;
    endfunction

endpackage

// File: rtl/sym9_decode.sv
module sym9_decode
    import sym9_pkg::*;
(
    input  logic [WORD_W-1:0] rec_word,
    output fix_t              fix
);
    logic [SYM_W-1:0] idx_one;
    logic [SYM_W-1:0] idx_zero;
    logic             unused_bits;

    assign idx_one  = rec_word[IDX_LSB +: SYM_W];
    assign idx_zero = idx_one - SYM_W'(1);

    always_comb begin
        fix.valid = (idx_one != '0);
        fix.addr  = byte_addr(idx_zero);
        fix.off   = idx_zero[2:0];
        fix.mask  = rec_word[MASK_LSB +: SYM_W];
    end

    assign unused_bits = ^{rec_word[WORD_W-1:IDX_LSB+SYM_W],
                           rec_word[IDX_LSB-1:MASK_LSB+SYM_W]};

endmodule

// File: rtl/sym9_merge.sv
module sym9_merge
    import sym9_pkg::*;
(
    input  logic [7:0]       lo_in,
    input  logic [7:0]       hi_in,
    input  logic [SYM_W-1:0] mask,
    input  logic [2:0]       off,
    output logic [7:0]       lo_out,
    output logic [7:0]       hi_out
);
    logic [15:0] flip;
    logic [15:0] merged;

    assign flip   = place_mask(mask, off);
    assign merged = {hi_in, lo_in} ^ flip;
    assign lo_out = merged[7:0];
    assign hi_out = merged[15:8];

    always_comb begin
        assert ($countones(flip) == $countones(mask))
            else $error("p_mask_kept_r7: placed mask lost bits");
    end

endmodule

// File: rtl/sym9_ctrl.sv
module sym9_ctrl
    import sym9_pkg::*;
#(
    parameter int MAX_REC = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [WORD_W-1:0]                  status_word,
    input  fix_t                               cur_fix,
    output logic [ptr_width(MAX_REC)-1:0]      rec_ptr,
    input  logic [7:0]                         mem_rdata,
    input  logic [7:0]                         new_lo,
    input  logic [7:0]                         new_hi,
    output logic [7:0]                         lo_q,
    output logic [7:0]                         hi_q,
    output logic                               mem_en,
    output logic                               mem_we,
    output logic [ADDR_W-1:0]                  mem_addr,
    output logic [7:0]                         mem_wdata,
    output logic                               busy,
    output logic                               done,
    output logic                               fail,
    output logic [cnt_width(MAX_REC)-1:0]      fix_count
);
    localparam int FIX_W = cnt_width(MAX_REC);
    localparam int PTR_W = ptr_width(MAX_REC);

    seq_state_t        state;
    logic [FIX_W-1:0]  n_q;
    logic              uncor_q;
    logic              st_err;
    logic              st_uncor;
    logic [CNT_W-1:0]  st_cnt;
    logic [FIX_W-1:0]  n_clamped;
    logic              last_rec;
    logic              unused_status;

    assign st_err   = status_word[ST_ERR_BIT];
    assign st_uncor = status_word[ST_UNCOR_BIT];
    assign st_cnt   = status_word[ST_CNT_LSB +: CNT_W];
    assign unused_status = ^status_word[ST_CNT_LSB-1:ST_UNCOR_BIT+1];

    assign n_clamped = (32'(st_cnt) > MAX_REC) ? FIX_W'(MAX_REC) : FIX_W'(st_cnt);
    assign last_rec  = (32'(rec_ptr) + 1 == 32'(n_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rec_ptr   <= '0;
            n_q       <= '0;
            uncor_q   <= 1'b0;
            lo_q      <= '0;
            hi_q      <= '0;
            fail      <= 1'b0;
            fix_count <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rec_ptr   <= '0;
                        fail      <= 1'b0;
                        fix_count <= '0;
                        uncor_q   <= st_err && st_uncor;
                        n_q       <= n_clamped;
                        if (!st_err) begin
                            state <= ST_FIN;
                        end else if (st_uncor) begin
                            fail  <= 1'b1;
                            state <= ST_FIN;
                        end else if (n_clamped == '0) begin
                            state <= ST_FIN;
                        end else begin
                            state <= ST_EVAL;
                        end
                    end
                end
                ST_EVAL:   state <= cur_fix.valid ? ST_RD_LO : ST_NEXT;
                ST_RD_LO:  state <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_q  <= mem_rdata;
                    state <= ST_MODIFY;
                end
                ST_MODIFY: begin
                    hi_q  <= mem_rdata;
                    state <= ST_WR_LO;
                end
                ST_WR_LO:  state <= ST_WR_HI;
                ST_WR_HI:  state <= ST_NEXT;
                ST_NEXT: begin
                    if (last_rec) begin
                        fix_count <= n_q;
                        state     <= ST_FIN;
                    end else begin
                        rec_ptr <= rec_ptr + PTR_W'(1);
                        state   <= ST_EVAL;
                    end
                end
                ST_FIN:    state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_fix.addr;
        mem_wdata = new_lo;
        case (state)
            ST_RD_LO: mem_en = 1'b1;
            ST_RD_HI: begin
                mem_en   = 1'b1;
                mem_addr = cur_fix.addr + ADDR_W'(1);
            end
            ST_WR_LO: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_WR_HI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_fix.addr + ADDR_W'(1);
                mem_wdata = new_hi;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    p_no_write_uncor_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !uncor_q);

    p_fail_no_fix_r3: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (fix_count == '0));

    p_skip_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_LO) |-> cur_fix.valid);

    p_addr_range_r6: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (32'(mem_addr) < MEM_BYTES));

    p_fix_bound_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(fix_count) <= MAX_REC));

    p_write_pair_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_LO) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    p_read_first_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_LO) |-> ($past(state, 3) == ST_RD_LO));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sym9_fixer.sv
module sym9_fixer
    import sym9_pkg::*;
#(
    parameter int MAX_REC = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [WORD_W-1:0]             status_word,
    input  logic [WORD_W*MAX_REC-1:0]     rec_words,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [7:0]                    mem_wdata,
    input  logic [7:0]                    mem_rdata,
    output logic                          busy,
    output logic                          done,
    output logic                          fail,
    output logic [cnt_width(MAX_REC)-1:0] fix_count
);
    localparam int PTR_W = ptr_width(MAX_REC);

    fix_t              fix_vec [MAX_REC];
    fix_t              cur_fix;
    logic [PTR_W-1:0]  rec_ptr;
    logic [7:0]        lo_q, hi_q, new_lo, new_hi;

    for (genvar k = 0; k < MAX_REC; k++) begin : g_rec
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (start && !busy)
                word_q <= rec_words[k*WORD_W +: WORD_W];
        end

        sym9_decode i_decode (
            .rec_word (word_q),
            .fix      (fix_vec[k])
        );
    end

    assign cur_fix = fix_vec[rec_ptr];

    sym9_merge i_merge (
        .lo_in  (lo_q),
        .hi_in  (hi_q),
        .mask   (cur_fix.mask),
        .off    (cur_fix.off),
        .lo_out (new_lo),
        .hi_out (new_hi)
    );

    sym9_ctrl #(.MAX_REC(MAX_REC)) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .status_word (status_word),
        .cur_fix     (cur_fix),
        .rec_ptr     (rec_ptr),
        .mem_rdata   (mem_rdata),
        .new_lo      (new_lo),
        .new_hi      (new_hi),
        .lo_q        (lo_q),
        .hi_q        (hi_q),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .fix_count   (fix_count)
    );

endmodule

// File: tb/test_sym9_fixer.sv
`timescale 1ns/1ps
module test_sym9_fixer;
    localparam int NREC  = 4;
    localparam int BYTES = 576;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [31:0]       status_word = '0;
    logic [32*NREC-1:0] rec_words = '0;
    logic              mem_en, mem_we;
    logic [9:0]        mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic              busy, done, fail;
    logic [2:0]        fix_count;

    logic [7:0] ram     [BYTES];
    logic [7:0] ref_mem [BYTES];
    int n_checks = 0;
    int n_fail   = 0;
    int wr_total = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    sym9_fixer #(.MAX_REC(NREC)) i_sym9_fixer (
        .clk(clk), .rst(rst), .start(start), .status_word(status_word),
        .rec_words(rec_words), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fix_count(fix_count)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                ram[mem_addr] <= mem_wdata;
                wr_total      <= wr_total + 1;
            end
            mem_rdata <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_status(input bit err, input bit unc, input int cnt);
        return {3'(cnt), 27'd0, unc, err};
    endfunction

    function automatic logic [31:0] mk_rec(input int sym1, input int mask);
        return {7'h7f, 9'(sym1), 7'h55, 9'(mask)};
    endfunction

    task automatic fill(input int seed);
        for (int k = 0; k < BYTES; k++) begin
            ram[k]     = 8'(k * 37 + seed);
            ref_mem[k] = 8'(k * 37 + seed);
        end
    endtask

    task automatic ref_apply(input int sym1, input int mask);
        int i, a;
        logic [15:0] w;
        if ((sym1 & 9'h1ff) == 0) return;
        i = (sym1 & 9'h1ff) - 1;
        a = i + (i >> 3);
        w = {ref_mem[a+1], ref_mem[a]};
        w = w ^ (16'(mask & 9'h1ff) << (i & 7));
        ref_mem[a]   = w[7:0];
        ref_mem[a+1] = w[15:8];
    endtask

    task automatic compare_ram(input string req);
        int bad = -1;
        for (int k = 0; k < BYTES; k++)
            if (bad < 0 && ram[k] !== ref_mem[k]) bad = k;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " ram byte"}, int'(ram[bad]), int'(ref_mem[bad]));
    endtask

    task automatic run_pass(input logic [31:0] st, input logic [32*NREC-1:0] recs,
                            input int exp_writes);
        int w0;
        w0 = wr_total;
        @(negedge clk);
        status_word = st;
        rec_words   = recs;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        status_word = '0;
        rec_words   = '1;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done, "R10 done pulse", int'(done), 0);
        check(wr_total - w0 == exp_writes, "R9 write count", wr_total - w0, exp_writes);
    endtask

    task automatic t_reset();
        check(!busy && !done && !fail && fix_count == 0 && !mem_en, "R10 reset state",
              int'({busy, done, fail, mem_en}), 0);
    endtask

    task automatic t_no_error();
        fill(3);
        run_pass(mk_status(0, 0, 3), {mk_rec(5, 'h1ff), mk_rec(9, 'h3), mk_rec(2, 'h7), mk_rec(1, 'h1)}, 0);
        check(!fail && fix_count == 0, "R4 clear error flag", int'(fix_count), 0);
        compare_ram("R4");
    endtask

    task automatic t_uncorrectable();
        fill(11);
        run_pass(mk_status(1, 1, 2), {64'd0, mk_rec(20, 'h1ff), mk_rec(3, 'h0f0)}, 0);
        check(fail == 1'b1, "R3 fail flag", int'(fail), 1);
        check(fix_count == 0, "R3 fix count", int'(fix_count), 0);
        compare_ram("R3");
    endtask

    task automatic t_single_low();
        fill(5);
        ref_apply(1, 'h1ff);
        run_pass(mk_status(1, 0, 1), {96'd0, mk_rec(1, 'h1ff)}, 2);
        check(!fail && fix_count == 1, "R1 single record count", int'(fix_count), 1);
        compare_ram("R6 R7 symbol 0");
    endtask

    task automatic t_straddle();
        fill(17);
        ref_apply(8, 'h155);
        ref_apply(511, 'h0ab);
        run_pass(mk_status(1, 0, 2), {64'd0, mk_rec(511, 'h0ab), mk_rec(8, 'h155)}, 4);
        check(fix_count == 2, "R2 count field", int'(fix_count), 2);
        compare_ram("R6 R7 offset 7 and last symbol");
    endtask

    task automatic t_skip_zero();
        fill(29);
        ref_apply(100, 'h0ff);
        run_pass(mk_status(1, 0, 3), {32'd0, mk_rec(0, 'h1ff), mk_rec(100, 'h0ff), mk_rec(0, 'h1ff)}, 2);
        check(fix_count == 3, "R5 skipped still counted", int'(fix_count), 3);
        compare_ram("R5 symbol 0 no effect");
    endtask

    task automatic t_order_clamp();
        fill(41);
        ref_apply(50, 'h1a5);
        ref_apply(50, 'h0f3);
        ref_apply(51, 'h101);
        ref_apply(300, 'h07e);
        run_pass(mk_status(1, 0, 7), {mk_rec(300, 'h07e), mk_rec(51, 'h101), mk_rec(50, 'h0f3), mk_rec(50, 'h1a5)}, 8);
        check(fix_count == 4, "R8 count clamped", int'(fix_count), 4);
        compare_ram("R8 sequential records");
    endtask

    task automatic t_hold();
        repeat (3) @(negedge clk);
        check(fix_count == 4 && !busy, "R10 result held", int'(fix_count), 4);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_error();
        t_uncorrectable();
        t_single_low();
        t_straddle();
        t_skip_zero();
        t_order_clamp();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule